// File: doc/BRIEF.md
# Dual-Channel Serial Controller Interrupt Logic

This block is the register-access and interrupt part of a two-channel serial controller. A CPU reaches it over a byte-wide bus. Two address bits select the channel and choose between a data access and a control access. Control accesses are indirect through a register pointer. A write to register 0 loads the pointer. The following control access then reaches the selected register, and the pointer falls back to 0.

Each channel samples a carrier-detect input. When the channel's mask allows it, any change of that level latches an external/status event. Once the channel's interrupt enable is set, that event becomes an interrupt request. A master enable gates the OR of the two requests onto one active-high interrupt output. A shared vector register can be read back through channel A. On that read, a 3-bit code naming the interrupting channel is written over a field of the vector. A master-control bit chooses where that field sits. Serial data transfer, baud generation and framing are not part of this block.

Top module: `scc_irq_ctl`

## Requirements
- R1: addr_i[0] selects the channel (0 = A, 1 = B). addr_i[1] = 1 marks a data access: a data read returns 0x00, and a data write changes no register and leaves the pointer unchanged.
- R2: A control write while the pointer is 0 loads the pointer. The pointer takes wdata_i[2:0], plus 8 when wdata_i[5:3] = 1. Any control read, and any control write while the pointer is not 0, returns the pointer to 0.
- R3: Control register 0 of a channel reads back as 0x08 when that channel's registered carrier-detect level is 1, and as 0x00 otherwise. The level is sampled on each clock edge.
- R4: A carrier-detect change in either direction sets the channel's pending flag and bit 3 of its status latch, which is read as control register 15. This happens only while bit 3 of the channel's mask register (write register 15) is 1; with the bit clear the change has no effect.
- R5: A control write of register 0 whose bits 5:3 equal 2 clears that channel's pending flag and status latch. If a carrier-detect change is latched in the same cycle, the set wins.
- R6: A channel requests an interrupt only while bit 0 of its write register 1 is 1 and its pending flag is set.
- R7: irq_o is 1 exactly when bit 3 of the shared master register (write register 9) is 1 and at least one channel requests.
- R8: Reading control register 2 through channel A returns the vector stored by write register 2. If a channel requests, the 3-bit field at bit 1 is replaced by 1 for A or 5 for B, with A taking priority. When master bit 4 is 1, the field sits at bit 4 instead. The same read through channel B returns 0x00.
- R9: After reset every register is zero: the pointer, masks, vector, master register, pending flags, latches and sampled levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Bus access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | bit 0 channel, bit 1 data/control |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid during a read cycle |
| dcd_i | input | 2 | Carrier-detect level, bit 0 channel A, bit 1 channel B |
| irq_o | output | 1 | Shared interrupt request, active high |

## Verification
A reset-status command and a carrier-detect transition can land on the same clock edge. The first clears the pending flag and latch, and the second sets them. The bench first clears channel B and confirms its latch reads 0. It then toggles channel B's carrier-detect input in the very cycle it issues the reset command. The collision is judged by reading register 15 afterwards: it must show 0x08, because the new event must not be lost.

// File: rtl/scc_irq_pkg.sv
package scc_irq_pkg;
  localparam int DW      = 8;
  localparam int PTR_W   = 4;
  localparam int CMD_LSB = 3;
  localparam int CMD_W   = 3;

  localparam logic [CMD_W-1:0] CMD_PTR_HI  = 3'd1;
  localparam logic [CMD_W-1:0] CMD_CLR_EXT = 3'd2;

  localparam logic [PTR_W-1:0] REG_CMD  = 4'd0;
  localparam logic [PTR_W-1:0] REG_IEN  = 4'd1;
  localparam logic [PTR_W-1:0] REG_VEC  = 4'd2;
  localparam logic [PTR_W-1:0] REG_MST  = 4'd9;
  localparam logic [PTR_W-1:0] REG_EXT  = 4'd15;

  localparam int DCD_BIT     = 3;
  localparam int IEN_EXT_BIT = 0;
  localparam int MST_IRQ_BIT = 3;
  localparam int MST_HI_BIT  = 4;

  localparam int FLD_W      = 3;
  localparam int FLD_LO_POS = 1;
  localparam int FLD_HI_POS = 4;
  localparam logic [FLD_W-1:0] CODE_A = 3'd1;
  localparam logic [FLD_W-1:0] CODE_B = 3'd5;
endpackage

// File: rtl/scc_chan.sv
module scc_chan
  import scc_irq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dcd_i,
  input  logic          ien_we_i,
  input  logic          msk_we_i,
  input  logic          clr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rr_lvl_o,
  output logic [DW-1:0] rr_ext_o,
  output logic          req_o
);
  logic          dcd_q;
  logic          pend_q;
  logic [DW-1:0] ext_q;
  logic [DW-1:0] ien_q;
  logic [DW-1:0] msk_q;
  logic          evt;

  assign evt = (dcd_i != dcd_q) && msk_q[DCD_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dcd_q  <= 1'b0;
      pend_q <= 1'b0;
      ext_q  <= '0;
      ien_q  <= '0;
      msk_q  <= '0;
    end else begin
      dcd_q <= dcd_i;
      if (ien_we_i) ien_q <= wdata_i;
      if (msk_we_i) msk_q <= wdata_i;
      // set beats clear so a same-cycle edge is not lost
      if (evt) begin
        pend_q         <= 1'b1;
        ext_q[DCD_BIT] <= 1'b1;
      end else if (clr_i) begin
        pend_q <= 1'b0;
        ext_q  <= '0;
      end
    end
  end

  always_comb begin
    rr_lvl_o          = '0;
    rr_lvl_o[DCD_BIT] = dcd_q;
  end
  assign rr_ext_o = ext_q;
  assign req_o    = ien_q[IEN_EXT_BIT] & pend_q;

  a_r3_level_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> rr_lvl_o[DCD_BIT] == $past(dcd_i));
  a_r4_edge_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dcd_i != dcd_q) && msk_q[DCD_BIT]) |=> (pend_q && rr_ext_o[DCD_BIT]));
  a_r4_masked_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!msk_q[DCD_BIT] && !clr_i) |=> $stable(pend_q) && $stable(ext_q));
  a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && (dcd_i == dcd_q)) |=> (!pend_q && rr_ext_o == '0));
endmodule

// File: rtl/scc_vec_patch.sv
module scc_vec_patch
  import scc_irq_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic [DW-1:0]     vec_i,
  input  logic [NUM_CH-1:0] req_i,
  input  logic              hi_i,
  output logic [DW-1:0]     vec_o
);
  localparam logic [FLD_W-1:0] FMASK = '1;

  logic [FLD_W-1:0] code;
  int unsigned      pos;

  always_comb begin
    code = '0;
    // lowest index wins: A before B
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (req_i[i]) code = (i == 0) ? CODE_A : CODE_B;
    end
    pos   = hi_i ? FLD_HI_POS : FLD_LO_POS;
    vec_o = vec_i;
    if (req_i != '0) begin
      vec_o = (vec_i & ~(DW'(FMASK) << pos)) | (DW'(code) << pos);
    end
  end

  always_comb begin
    if (req_i == '0) a_r8_no_req_raw: assert (vec_o == vec_i);
  end
endmodule

// File: rtl/scc_irq_ctl.sv
module scc_irq_ctl
  import scc_irq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          we_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [1:0]    dcd_i,
  output logic          irq_o
);
  localparam int NUM_CH = 2;
  localparam int CH_W   = $clog2(NUM_CH);

  logic [PTR_W-1:0] ptr_q;
  logic [DW-1:0]    vec_q;
  logic [DW-1:0]    mst_q;
  logic             ctl_wr, ctl_rd;
  logic [CH_W-1:0]  ch;
  logic [CMD_W-1:0] cmd;
  logic [DW-1:0]    vec_rd;
  logic [NUM_CH-1:0] req;
  logic [DW-1:0]    rr_lvl [NUM_CH];
  logic [DW-1:0]    rr_ext [NUM_CH];

  assign ctl_wr = cs_i & ~addr_i[1] & we_i;
  assign ctl_rd = cs_i & ~addr_i[1] & ~we_i;
  assign ch     = addr_i[0];
  assign cmd    = wdata_i[CMD_LSB +: CMD_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      vec_q <= '0;
      mst_q <= '0;
    end else begin
      if (ctl_rd) begin
        ptr_q <= '0;
      end else if (ctl_wr) begin
        if (ptr_q == REG_CMD) ptr_q <= {cmd == CMD_PTR_HI, wdata_i[2:0]};
        else                  ptr_q <= '0;
        if (ptr_q == REG_VEC) vec_q <= wdata_i;
        if (ptr_q == REG_MST) mst_q <= wdata_i;
      end
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic sel;
    assign sel = (ch == CH_W'(g));
    scc_chan u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .dcd_i    (dcd_i[g]),
      .ien_we_i (ctl_wr && sel && ptr_q == REG_IEN),
      .msk_we_i (ctl_wr && sel && ptr_q == REG_EXT),
      .clr_i    (ctl_wr && sel && ptr_q == REG_CMD && cmd == CMD_CLR_EXT),
      .wdata_i  (wdata_i),
      .rr_lvl_o (rr_lvl[g]),
      .rr_ext_o (rr_ext[g]),
      .req_o    (req[g])
    );
  end

  scc_vec_patch #(.NUM_CH(NUM_CH)) u_vec (
    .vec_i (vec_q),
    .req_i (req),
    .hi_i  (mst_q[MST_HI_BIT]),
    .vec_o (vec_rd)
  );

  always_comb begin
    rdata_o = '0;
    if (ctl_rd) begin
      unique case (ptr_q)
        REG_CMD: rdata_o = rr_lvl[ch];
        REG_EXT: rdata_o = rr_ext[ch];
        REG_VEC: rdata_o = (ch == '0) ? vec_rd : '0;
        default: rdata_o = '0;
      endcase
    end
  end

  assign irq_o = mst_q[MST_IRQ_BIT] & (|req);

  a_r2_ptr_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_rd |=> ptr_q == '0);
  a_r1_data_keeps_ptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && addr_i[1]) |=> $stable(ptr_q) && $stable(vec_q) && $stable(mst_q));
  a_r1_data_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && addr_i[1] && !we_i) |-> rdata_o == '0);
  a_r7_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (mst_q[MST_IRQ_BIT] && req != '0));
endmodule

// File: tb/scc_irq_ctl_tb.sv
module scc_irq_ctl_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_i = 1'b0, we_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [1:0] dcd_i = '0;
  logic       irq_o;

  typedef struct {
    logic [7:0] exp;
    bit         is_irq;
    string      req;
  } item_t;

  item_t q[$];
  bit    probe = 1'b0;
  int    n_chk = 0, n_err = 0;
  bit    done = 1'b0;

  always #4 clk_i = ~clk_i;

  scc_irq_ctl u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .dcd_i(dcd_i), .irq_o(irq_o)
  );

  // monitor: pops expectations while a probe cycle is active
  always @(negedge clk_i) begin
    if (probe && q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it  = q.pop_front();
      act = it.is_irq ? {7'd0, irq_o} : rdata_o;
      n_chk++;
      if (act !== it.exp) begin
        n_err++;
        $display("FAIL %s: actual=%02h expected=%02h", it.req, act, it.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cs_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    step();
    cs_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string r);
    item_t it;
    it.exp = e; it.is_irq = 1'b0; it.req = r;
    q.push_back(it);
    cs_i = 1'b1; we_i = 1'b0; addr_i = a; probe = 1'b1;
    step();
    cs_i = 1'b0; probe = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string r);
    item_t it;
    it.exp = {7'd0, e}; it.is_irq = 1'b1; it.req = r;
    q.push_back(it);
    probe = 1'b1;
    step();
    probe = 1'b0;
  endtask

  // control register write / read through the pointer; a = channel
  task automatic wreg(input logic a, input logic [3:0] n, input logic [7:0] d);
    wr({1'b0, a}, {4'd0, n});
    wr({1'b0, a}, d);
  endtask

  task automatic rreg(input logic a, input logic [3:0] n, input logic [7:0] e, input string r);
    if (n != 0) wr({1'b0, a}, {4'd0, n});
    rd({1'b0, a}, e, r);
  endtask

  initial begin
    fork
      begin
        repeat (3) step();
        rst_ni = 1'b1;
        step();
        // R9 reset state
        rreg(0, 4'd0, 8'h00, "R9 rr0 A");
        rreg(1, 4'd15, 8'h00, "R9 rr15 B");
        rreg(0, 4'd2, 8'h00, "R9 vector");
        chk_irq(1'b0, "R9 irq");
        // R1 data access
        rd(2'b10, 8'h00, "R1 data read A");
        wreg(0, 4'd2, 8'hA5);
        wr(2'b10, 8'h0F);
        rreg(0, 4'd0, 8'h00, "R1 data write leaves pointer at 0");
        rreg(0, 4'd2, 8'hA5, "R8 raw vector");
        rreg(1, 4'd2, 8'h00, "R8 read via B");
        // arm A
        wreg(0, 4'd15, 8'h08);
        wreg(0, 4'd1, 8'h01);
        wreg(0, 4'd9, 8'h08);
        dcd_i[0] = 1'b1;
        step(); step();
        rreg(0, 4'd0, 8'h08, "R3 rr0 A level");
        rd(2'b00, 8'h08, "R2 pointer back at 0");
        rreg(0, 4'd15, 8'h08, "R4 rising edge latched");
        chk_irq(1'b1, "R7 irq A");
        rreg(0, 4'd2, 8'hA3, "R8 A code at bit 1");
        wreg(0, 4'd9, 8'h18);
        rreg(0, 4'd2, 8'h95, "R8 A code at bit 4");
        wreg(0, 4'd9, 8'h00);
        chk_irq(1'b0, "R7 master off");
        wreg(0, 4'd9, 8'h08);
        // B masked
        dcd_i[1] = 1'b1;
        step(); step();
        rreg(1, 4'd15, 8'h00, "R4 masked change ignored");
        rreg(1, 4'd0, 8'h08, "R3 rr0 B level");
        // clear A
        wr(2'b00, 8'h10);
        rreg(0, 4'd15, 8'h00, "R5 clear latch");
        chk_irq(1'b0, "R5 clear removes irq");
        // B falling edge
        wreg(1, 4'd15, 8'h08);
        wreg(1, 4'd1, 8'h01);
        dcd_i[1] = 1'b0;
        step(); step();
        chk_irq(1'b1, "R7 irq B");
        rreg(0, 4'd2, 8'hAB, "R8 B code");
        dcd_i[0] = 1'b0;
        step(); step();
        rreg(0, 4'd2, 8'hA3, "R8 A priority over B");
        // point-high selects register 15
        wr(2'b00, 8'h0F);
        rd(2'b00, 8'h08, "R2 point high");
        // R6: B pending but enable off
        wreg(1, 4'd1, 8'h00);
        wr(2'b00, 8'h10);
        rreg(1, 4'd15, 8'h08, "R6 B still pending");
        chk_irq(1'b0, "R6 enable off");
        rreg(0, 4'd2, 8'hA5, "R6 no request raw vector");
        // R5 collision
        wr(2'b01, 8'h10);
        rreg(1, 4'd15, 8'h00, "R5 B cleared");
        cs_i = 1'b1; we_i = 1'b1; addr_i = 2'b01; wdata_i = 8'h10;
        dcd_i[1] = 1'b1;
        step();
        cs_i = 1'b0; we_i = 1'b0;
        rreg(1, 4'd15, 8'h08, "R5 set wins over clear");
        step(); step();
        done = 1'b1;
      end
      begin
        repeat (20000) @(posedge clk_i);
        if (!done) begin
          n_chk++; n_err++;
          $display("FAIL watchdog: actual=timeout expected=done");
        end
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule